// File: doc/BRIEF.md
# Self-Timed Successive-Approximation Conversion Sequencer

This block is the digital controller of a 12-bit successive-approximation converter. It runs on its own converter clock, which has no tie to the serial bus that requests conversions. A start request arrives asynchronously, is brought into the converter clock domain, and its rising edge opens a fixed acquisition window. During that window the sample switch is closed. When the window ends, the switch opens and a binary search resolves one bit per fixed-length slot, most significant bit first. The search drives a DAC code and reads back a single comparator decision.

When the last bit is decided, the finished word is written into a result register in one step and a one-cycle completion pulse is raised. A reader in another domain may sample the result at any moment and never sees a half-built word. Rising edges of the start request that arrive while a conversion is under way are dropped.

Top module: `sar_conv_seq`

## Requirements
- R1: While reset is held and right after it is released, `sample_en`, `busy`, `done` are 0 and `result` and `dac_code` are all zeros.
- R2: A rising edge on `start_req` seen by the converter clock raises `sample_en` and `busy` after the third rising clock edge that samples it high. `sample_en` then stays high for exactly `ACQ_CLKS` cycles, and `dac_code` is zero throughout.
- R3: After acquisition `sample_en` is low and the bits are resolved from bit 11 down to bit 0, each in a slot of `BIT_CLKS` cycles. In the first cycle of the slot for bit b, `dac_code` holds the bits already decided above b, a 1 at b, and zeros below b.
- R4: At the final cycle of each slot, the trial bit is kept when `cmp_hi` is 1 (input at or above the DAC level) and cleared when it is 0. A comparator stuck at 1 therefore yields 4095 and one stuck at 0 yields 0.
- R5: `done` is high for exactly one cycle, `ACQ_CLKS + 12*BIT_CLKS` cycles after `sample_en` first rises. In that same cycle `result` takes the new straight-binary code and `busy` falls. With an ideal comparator the code equals the input level, including 0 and 4095.
- R6: `result` keeps its previous value during the whole acquisition and search, and changes only in the cycle where `done` is high.
- R7: A rising edge of `start_req` during acquisition or search neither restarts the conversion nor starts another one after it.
- R8: Holding `start_req` high starts exactly one conversion. Another one needs a fall and a new rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock from the internal oscillator |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Asynchronous conversion request; its rising edge counts |
| cmp_hi | input | 1 | Comparator: 1 when the held input is at or above the DAC level |
| dac_code | output | 12 | Trial code applied to the DAC |
| sample_en | output | 1 | Closes the sample switch during acquisition |
| busy | output | 1 | High from the start of acquisition until the result is written |
| done | output | 1 | One-cycle pulse when the result register is updated |
| result | output | 12 | Last finished conversion code, straight binary |

## Verification
The bench raises `start_req` just after a falling edge and counts falling edges from there. `sample_en` must first read high at the third count, the first trial code at count `3 + ACQ_CLKS`, and each later slot `BIT_CLKS` counts later. `done` and the new `result` must appear at count `3 + ACQ_CLKS + 12*BIT_CLKS` and at no other count. Every output is sampled on the falling edge at each count, and before the done count `result` is compared against the value it held before the start. Requests injected mid-conversion or held high are followed by a quiet stretch in which `busy` and `done` must stay low.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACQ  = 2'd1,
    ST_CONV = 2'd2
  } seq_state_t;
endpackage

// File: rtl/sar_start_sync.sv
module sar_start_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic req_async,
  output logic req_rise
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= req_async;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign req_rise = sync_q & ~prev_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_rise |=> !req_rise); // R8
endmodule

// File: rtl/sar_slot_timer.sv
module sar_slot_timer #(
  parameter int ACQ_CLKS = 8,
  parameter int BIT_CLKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic acq_phase,
  output logic slot_last
);
  localparam int MAXC = (ACQ_CLKS > BIT_CLKS) ? ACQ_CLKS : BIT_CLKS;
  localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] ACQ_END = CW'(ACQ_CLKS - 1);
  localparam logic [CW-1:0] BIT_END = CW'(BIT_CLKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign slot_last = run && (cnt_q == (acq_phase ? ACQ_END : BIT_END));
  assign cnt_en    = run || (cnt_q != '0);

  always_comb begin
    if (!run || slot_last) cnt_d = '0;
    else                   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= (acq_phase ? ACQ_END : BIT_END))); // R3
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
  parameter int BITS = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            load_msb,
  input  logic            decide,
  input  logic            cmp_hi,
  output logic [BITS-1:0] trial,
  output logic [BITS-1:0] word_final,
  output logic            last_bit
);
  localparam logic [BITS-1:0] MSB_ONLY = {1'b1, {(BITS-1){1'b0}}};

  logic [BITS-1:0] trial_q, ptr_q, shifted_in, trial_step;
  logic [BITS-1:0] trial_d, ptr_d;
  logic            reg_en;

  for (genvar i = 0; i < BITS; i++) begin : g_bit
    if (i == BITS - 1) begin : g_top
      assign shifted_in[i] = 1'b0;
    end else begin : g_low
      assign shifted_in[i] = ptr_q[i+1];
    end
    assign word_final[i] = ptr_q[i] ? cmp_hi : trial_q[i];
    assign trial_step[i] = word_final[i] | shifted_in[i];
  end

  assign reg_en = clr | load_msb | decide;

  always_comb begin
    if (clr) begin
      trial_d = '0;
      ptr_d   = '0;
    end else if (load_msb) begin
      trial_d = MSB_ONLY;
      ptr_d   = MSB_ONLY;
    end else begin
      trial_d = trial_step;
      ptr_d   = ptr_q >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial_q <= '0;
      ptr_q   <= '0;
    end else if (reg_en) begin
      trial_q <= trial_d;
      ptr_q   <= ptr_d;
    end
  end

  assign trial    = trial_q;
  assign last_bit = ptr_q[0];

  AST_PTR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ptr_q)); // R3
  AST_BELOW_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ((trial_q & (ptr_q - 1'b1)) == '0) || (ptr_q == '0)); // R3
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq #(
  parameter int BITS     = 12,
  parameter int ACQ_CLKS = 8,
  parameter int BIT_CLKS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_req,
  input  logic            cmp_hi,
  output logic [BITS-1:0] dac_code,
  output logic            sample_en,
  output logic            busy,
  output logic            done,
  output logic [BITS-1:0] result
);
  import sar_seq_pkg::*;

  seq_state_t      state_q, state_d;
  logic            start_rise, slot_last, last_bit;
  logic            load_msb, decide, result_we;
  logic [BITS-1:0] trial, word_final;
  logic [BITS-1:0] result_q;
  logic            done_q;

  sar_start_sync u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_async (start_req),
    .req_rise  (start_rise)
  );

  sar_slot_timer #(.ACQ_CLKS(ACQ_CLKS), .BIT_CLKS(BIT_CLKS)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (state_q != ST_IDLE),
    .acq_phase (state_q == ST_ACQ),
    .slot_last (slot_last)
  );

  sar_trial_reg #(.BITS(BITS)) u_trial (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (result_we),
    .load_msb   (load_msb),
    .decide     (decide),
    .cmp_hi     (cmp_hi),
    .trial      (trial),
    .word_final (word_final),
    .last_bit   (last_bit)
  );

  always_comb begin
    state_d   = state_q;
    load_msb  = 1'b0;
    decide    = 1'b0;
    result_we = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_rise) state_d = ST_ACQ;
      ST_ACQ: if (slot_last) begin
        state_d  = ST_CONV;
        load_msb = 1'b1;
      end
      ST_CONV: if (slot_last) begin
        decide = 1'b1;
        if (last_bit) begin
          result_we = 1'b1;
          state_d   = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= result_we;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         result_q <= '0;
    else if (result_we) result_q <= word_final;
  end

  assign dac_code  = trial;
  assign sample_en = (state_q == ST_ACQ);
  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign result    = result_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result)); // R6
  AST_ACQ_DAC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> (dac_code == '0)); // R2
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sample_en) |-> !$past(busy)); // R7
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R5
endmodule

// File: tb/sar_conv_seq_test.sv
module sar_conv_seq_test;
  localparam int BITS     = 12;
  localparam int ACQ_CLKS = 8;
  localparam int BIT_CLKS = 8;
  localparam int T_ACQ    = 3;
  localparam int T_DONE   = T_ACQ + ACQ_CLKS + BITS * BIT_CLKS;

  logic            clk, rst_n, start_req;
  logic            cmp_hi;
  logic [BITS-1:0] dac_code, result;
  logic            sample_en, busy, done;

  logic [BITS-1:0] vin_r;
  int              cmp_mode;
  int              n_chk, n_fail;

  sar_conv_seq #(.BITS(BITS), .ACQ_CLKS(ACQ_CLKS), .BIT_CLKS(BIT_CLKS)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .cmp_hi    (cmp_hi),
    .dac_code  (dac_code),
    .sample_en (sample_en),
    .busy      (busy),
    .done      (done),
    .result    (result)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  assign cmp_hi = (cmp_mode == 1) ? 1'b1 :
                  (cmp_mode == 2) ? 1'b0 : (vin_r >= dac_code);

  function automatic logic [BITS-1:0] exp_code(input logic [BITS-1:0] v, input int mode);
    if (mode == 1)      return {BITS{1'b1}};
    else if (mode == 2) return '0;
    else                return v;
  endfunction

  function automatic logic [BITS-1:0] exp_dac(input logic [BITS-1:0] v, input int k);
    int b;
    logic [BITS-1:0] upper;
    b = BITS - 1 - k;
    upper = (b == BITS - 1) ? '0 : ((v >> (b + 1)) << (b + 1));
    return upper | (BITS'(1) << b);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_conv(input logic [BITS-1:0] v, input int mode,
                          input bit poke_mid, input bit hold_high);
    logic [BITS-1:0] prev;
    int k;
    vin_r    = v;
    cmp_mode = mode;
    @(negedge clk);
    prev = result;
    start_req = 1'b1;
    for (int n = 1; n <= T_DONE + 24; n++) begin
      @(negedge clk);
      if (n == 2 && !hold_high) start_req = 1'b0;
      if (poke_mid && n == 40) start_req = 1'b1;
      if (poke_mid && n == 43) start_req = 1'b0;
      if (n == 1 || n == 2)
        chk(!sample_en && !busy, "R2 early", {sample_en, busy}, 0);
      else if (n < T_ACQ + ACQ_CLKS) begin
        chk(sample_en && busy, "R2 acq", {sample_en, busy}, 3);
        chk(dac_code == '0, "R2 dac zero", dac_code, 0);
      end
      if (n >= T_ACQ + ACQ_CLKS && n < T_DONE) begin
        chk(!sample_en && busy, "R3 conv", {sample_en, busy}, 1);
        k = (n - T_ACQ - ACQ_CLKS) / BIT_CLKS;
        if (mode == 0 && ((n - T_ACQ - ACQ_CLKS) % BIT_CLKS) == 0)
          chk(dac_code == exp_dac(v, k), "R3 trial", dac_code, exp_dac(v, k));
      end
      if (n < T_DONE) begin
        chk(!done, "R5 early done", done, 0);
        chk(result == prev, "R6 hold", result, prev);
      end else if (n == T_DONE) begin
        chk(done && !busy, "R5 done", {done, busy}, 2);
        chk(result == exp_code(v, mode), "R4 R5 result", result, exp_code(v, mode));
      end else begin
        chk(!done && !busy, "R7 R8 quiet", {done, busy}, 0);
        chk(result == exp_code(v, mode), "R6 kept", result, exp_code(v, mode));
      end
    end
    start_req = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    vin_r = '0; cmp_mode = 0;
    start_req = 1'b0;
    rst_n = 1'b0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!sample_en && !busy && !done, "R1 reset ctl", {sample_en, busy, done}, 0);
    chk(result == '0 && dac_code == '0, "R1 reset data", {result, dac_code}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && result == '0, "R1 after release", {busy, result}, 0);

    run_conv(12'h000, 0, 1'b0, 1'b0);   // R5 lowest code
    run_conv(12'hFFF, 0, 1'b0, 1'b0);   // R5 highest code
    run_conv(12'h800, 0, 1'b0, 1'b0);
    run_conv(12'h7FF, 0, 1'b0, 1'b0);
    run_conv(12'h5A3, 1, 1'b0, 1'b0);   // R4 stuck high
    run_conv(12'h5A3, 2, 1'b0, 1'b0);   // R4 stuck low
    run_conv(12'h3C5, 0, 1'b1, 1'b0);   // R7 mid-conversion request
    run_conv(12'hA5A, 0, 1'b0, 1'b1);   // R8 level held
    for (int i = 0; i < 40; i++)
      run_conv(BITS'($urandom), 0, ($urandom % 4) == 0, ($urandom % 4) == 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule